// File: doc/BRIEF.md
# Programmable Prioritized Interrupt Controller

The block collects eight interrupt request inputs, latches them into a request register and filters them through a mask register. A fixed-priority arbiter then picks the most urgent request that is not blocked by a level already in service. While such a request exists the controller holds its interrupt output high. When the processor acknowledges with a one-cycle pulse, the block returns an 8-bit vector, which is the programmed base plus the input index. It then marks that level as in service. Service ends in one of two ways: software writes a specific end-of-interrupt command, or, in automatic mode, the in-service bit is never set.

Software reaches the block through a small register port. One address carries commands and one carries data, and a third address holds the per-input trigger register that picks edge or level sensing. After reset the controller must be programmed with an ordered initialization sequence before it raises any interrupt. Command-port reads return either the request register or the in-service register. A readback-select command picks which one. If a request disappears before it is acknowledged, the block answers with the vector of the lowest-priority input and does not set an in-service bit.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `int_o` is low, the mask register (address 1) reads 0xFF, the request register readback (address 0) reads 0x00, the trigger register (address 2) reads 0x00 and `vec_vld_o` is low.
- R2: A command write (address 0) with bit 4 set starts initialization and clears the in-service register. The value 0x11 additionally announces that a cascade word and a mode word follow. The next data writes (address 1) are then taken in order as vector base, cascade word and mode word. Only after the mode word do data writes load the mask. Data writes before the first complete sequence, or inside one, leave the mask unchanged. `int_o` stays low until the sequence completes.
- R3: Priority is fixed with input 0 highest. The vector returned for input n is the programmed base plus n.
- R4: `int_o` is high exactly when the sequence is complete and some request bit is set, unmasked, and of strictly higher priority than every set in-service bit. It reflects a change on `irq_i` or in the registers one clock edge later.
- R5: An `inta_i` pulse sampled at a clock edge presents the vector on `vec_o` with `vec_vld_o` high after that edge. For a real request, and when automatic end of service is off, it sets the in-service bit of the chosen input.
- R6: A command write of 0x60 plus n (n = 0 to 7) clears in-service bit n only.
- R7: When bit 1 of the mode word is set, acknowledge sets no in-service bit, so later requests are never blocked by earlier ones.
- R8: Command write 0x0A selects the request register and 0x0B selects the in-service register for address-0 reads. The choice persists until changed. Address-1 reads return the mask.
- R9: A set mask bit keeps its input from raising `int_o` while its request bit stays latched. A mask of 0xFF blocks all inputs.
- R10: An acknowledge with no eligible request returns base plus 7 and leaves the in-service register unchanged, even when input 7 is masked.
- R11: In the trigger register at address 2, bit n = 1 selects level sensing and 0 selects edge sensing. Bits 0 to 2 are reserved: they read as zero and their inputs stay edge-sensed.
- R12: In edge mode a rising input sets the request bit, which holds until acknowledge clears it. In level mode the request bit follows the input and is not cleared by acknowledge.
- R13: A set in-service bit blocks requests of equal or lower priority. A higher-priority request still raises `int_o` and nests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 command, 1 data, 2 trigger |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_i | input | 8 | Interrupt request inputs |
| inta_i | input | 1 | Acknowledge pulse from the processor |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Acknowledged vector |
| vec_vld_o | output | 1 | Vector valid, one cycle after acknowledge |

## Verification
Every result of this block is due exactly one rising edge after its stimulus. Request, mask, trigger and command writes update registers at that edge, and `int_o` and `rdata_o` follow them combinationally. The vector is registered at the edge that samples `inta_i`. The bench drives inputs just after a falling edge and samples at the following falling edge, so each check sees the state after precisely one rising edge. A sweep over all 255 request patterns drains each pattern by acknowledge and end-of-interrupt. It compares every vector against the lowest set index computed in the bench.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE,
    ST_CASC,
    ST_MODE,
    ST_RUN
  } init_st_e;

  localparam logic [1:0] ADDR_CMD  = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_TRIG = 2'd2;

  localparam logic [7:0] CMD_SEL_IRR = 8'h0A;
  localparam logic [7:0] CMD_SEL_ISR = 8'h0B;
  localparam logic [4:0] CMD_EOI_TAG = 5'b01100;

  localparam int unsigned START_BIT  = 4;
  localparam int unsigned SINGLE_BIT = 1;
  localparam int unsigned MODEW_BIT  = 0;
  localparam int unsigned AEOI_BIT   = 1;

endpackage

// File: rtl/prio_irq_cfg.sv
module prio_irq_cfg
  import prio_irq_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_wr_i,
  input  logic          data_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic          init_start_o,
  output logic          mask_wr_o,
  output logic [DW-1:0] base_o,
  output logic          aeoi_o
);

  init_st_e      st_q, st_d;
  logic          single_q, want_mode_q, aeoi_q;
  logic [DW-1:0] base_q;
  logic          start;

  assign start = cmd_wr_i && wdata_i[START_BIT];

  always_comb begin
    st_d = st_q;
    if (start) begin
      st_d = ST_BASE;
    end else if (data_wr_i) begin
      unique case (st_q)
        ST_BASE: st_d = single_q ? (want_mode_q ? ST_MODE : ST_RUN) : ST_CASC;
        ST_CASC: st_d = want_mode_q ? ST_MODE : ST_RUN;
        ST_MODE: st_d = ST_RUN;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      single_q    <= 1'b0;
      want_mode_q <= 1'b0;
      aeoi_q      <= 1'b0;
      base_q      <= '0;
    end else begin
      st_q <= st_d;
      if (start) begin
        single_q    <= wdata_i[SINGLE_BIT];
        want_mode_q <= wdata_i[MODEW_BIT];
        aeoi_q      <= 1'b0;
      end else if (data_wr_i && st_q == ST_BASE) begin
        base_q <= wdata_i;
      end else if (data_wr_i && st_q == ST_MODE) begin
        aeoi_q <= wdata_i[AEOI_BIT];
      end
    end
  end

  assign ready_o      = (st_q == ST_RUN);
  assign init_start_o = start;
  assign mask_wr_o    = data_wr_i && (st_q == ST_RUN);
  assign base_o       = base_q;
  assign aeoi_o       = aeoi_q;

  // R2
  mode_then_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_MODE && data_wr_i && !start) |=> ready_o);

  // R2
  start_leaves_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !ready_o);

endmodule

// File: rtl/prio_irq_req.sv
module prio_irq_req #(
  parameter int unsigned N_IN = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_IN-1:0] irq_i,
  input  logic [N_IN-1:0] level_i,
  input  logic [N_IN-1:0] ack_clr_i,
  output logic [N_IN-1:0] irr_o
);

  for (genvar g = 0; g < N_IN; g++) begin : g_in
    logic prev_q, irr_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        irr_q  <= 1'b0;
      end else begin
        prev_q <= irq_i[g];
        if (level_i[g])                  irr_q <= irq_i[g];
        else if (irq_i[g] && !prev_q)    irr_q <= 1'b1;
        else if (ack_clr_i[g])           irr_q <= 1'b0;
      end
    end

    assign irr_o[g] = irr_q;

    // R12
    edge_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!level_i[g] && irq_i[g] && !prev_q) |=> irr_q);

    // R12
    level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      level_i[g] |=> (irr_q == $past(irq_i[g])));
  end

endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
  parameter int unsigned N_IN  = 8,
  parameter int unsigned IDX_W = $clog2(N_IN)
) (
  input  logic [N_IN-1:0]  irr_i,
  input  logic [N_IN-1:0]  mask_i,
  input  logic [N_IN-1:0]  isr_i,
  output logic             win_vld_o,
  output logic [IDX_W-1:0] win_idx_o
);

  logic [N_IN-1:0] elig;
  int              lim;

  always_comb begin
    elig = irr_i & ~mask_i;
    lim  = N_IN;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (isr_i[i]) lim = i;
    end
    win_vld_o = 1'b0;
    win_idx_o = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (elig[i] && i < lim) begin
        win_vld_o = 1'b1;
        win_idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned N_IN      = 8,
  parameter int unsigned DW        = 8,
  parameter logic [7:0]  TRIG_KEEP = 8'hF8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [1:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [N_IN-1:0] irq_i,
  input  logic            inta_i,
  output logic            int_o,
  output logic [DW-1:0]   vec_o,
  output logic            vec_vld_o
);

  localparam int unsigned IDX_W    = $clog2(N_IN);
  localparam int unsigned SPUR_IDX = N_IN - 1;
  localparam logic [N_IN-1:0] KEEP = TRIG_KEEP[N_IN-1:0];

  logic            cmd_wr, data_wr, trig_wr;
  logic            ready, init_start, mask_wr, aeoi;
  logic [DW-1:0]   base;
  logic [N_IN-1:0] irr, mask_q, trig_q, isr_q;
  logic [N_IN-1:0] ack_set, eoi_clr;
  logic            win_vld, take, sel_isr_q, eoi_hit;
  logic [IDX_W-1:0] win_idx;
  logic [DW-1:0]   vec_q;
  logic            vec_vld_q;

  assign cmd_wr  = wr_i && addr_i == ADDR_CMD;
  assign data_wr = wr_i && addr_i == ADDR_DATA;
  assign trig_wr = wr_i && addr_i == ADDR_TRIG;

  prio_irq_cfg #(.DW(DW)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_wr_i    (cmd_wr),
    .data_wr_i   (data_wr),
    .wdata_i     (wdata_i),
    .ready_o     (ready),
    .init_start_o(init_start),
    .mask_wr_o   (mask_wr),
    .base_o      (base),
    .aeoi_o      (aeoi)
  );

  prio_irq_req #(.N_IN(N_IN)) u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .irq_i    (irq_i),
    .level_i  (trig_q),
    .ack_clr_i(ack_set),
    .irr_o    (irr)
  );

  prio_irq_arb #(.N_IN(N_IN), .IDX_W(IDX_W)) u_arb (
    .irr_i    (irr),
    .mask_i   (mask_q),
    .isr_i    (isr_q),
    .win_vld_o(win_vld),
    .win_idx_o(win_idx)
  );

  assign int_o   = ready && win_vld;
  assign take    = inta_i && int_o;
  assign ack_set = take ? (N_IN'(1) << win_idx) : '0;
  assign eoi_hit = cmd_wr && !wdata_i[START_BIT] && wdata_i[7:3] == CMD_EOI_TAG;
  assign eoi_clr = eoi_hit ? (N_IN'(1) << wdata_i[2:0]) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q <= '0;
    end else if (init_start) begin
      isr_q <= '0;
    end else begin
      isr_q <= (isr_q & ~eoi_clr) | (aeoi ? '0 : ack_set);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q    <= '1;
      trig_q    <= '0;
      sel_isr_q <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= wdata_i[N_IN-1:0];
      if (trig_wr) trig_q <= wdata_i[N_IN-1:0] & KEEP;
      if (cmd_wr && wdata_i == CMD_SEL_IRR) sel_isr_q <= 1'b0;
      if (cmd_wr && wdata_i == CMD_SEL_ISR) sel_isr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q     <= '0;
      vec_vld_q <= 1'b0;
    end else begin
      vec_vld_q <= inta_i;
      if (inta_i) vec_q <= base + (take ? DW'(win_idx) : DW'(SPUR_IDX));
    end
  end

  assign vec_o     = vec_q;
  assign vec_vld_o = vec_vld_q;

  always_comb begin
    unique case (addr_i)
      ADDR_CMD:  rdata_o = sel_isr_q ? DW'(isr_q) : DW'(irr);
      ADDR_DATA: rdata_o = DW'(mask_q);
      ADDR_TRIG: rdata_o = DW'(trig_q);
      default:   rdata_o = '0;
    endcase
  end

  // R5
  ack_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i |=> vec_vld_o);

  // R10
  spur_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !int_o && !cmd_wr) |=> (isr_q == $past(isr_q)));

  // R7
  aeoi_no_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aeoi && inta_i) |=> ((isr_q & ~$past(isr_q)) == '0));

  // R13
  nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((isr_q & ((N_IN'(2) << win_idx) - N_IN'(1))) == '0));

  // R9
  win_unmasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (irr[win_idx] && !mask_q[win_idx]));

  // R2
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready |=> (mask_q == $past(mask_q)));

endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic [7:0] irq_i = 8'h00;
  logic       inta_i = 1'b0;
  logic       int_o;
  logic [7:0] vec_o;
  logic       vec_vld_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .irq_i    (irq_i),
    .inta_i   (inta_i),
    .int_o    (int_o),
    .vec_o    (vec_o),
    .vec_vld_o(vec_vld_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic pulse(input logic [7:0] p);
    irq_i = irq_i | p;
    @(negedge clk);
    irq_i = irq_i & ~p;
  endtask

  task automatic ack(output logic [7:0] v);
    inta_i = 1'b1;
    @(negedge clk);
    inta_i = 1'b0;
    chk("R5 vld", {7'd0, vec_vld_o}, 8'h01);
    v = vec_o;
  endtask

  function automatic int lowest(input logic [7:0] p);
    for (int i = 7; i >= 0; i--) if (p[i]) lowest = i;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic [7:0] v, r;
    logic [7:0] pend;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 int", {7'd0, int_o}, 8'h00);
    chk("R1 vld", {7'd0, vec_vld_o}, 8'h00);
    rd(1, r); chk("R1 mask", r, 8'hFF);
    rd(0, r); chk("R1 irr", r, 8'h00);
    rd(2, r); chk("R1 trig", r, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 mask write before init ignored
    wr(1, 8'h00);
    rd(1, r); chk("R2 pre-init mask", r, 8'hFF);
    wr(0, 8'h11);
    wr(1, 8'h30);
    rd(1, r); chk("R2 mid-init mask", r, 8'hFF);
    wr(1, 8'h04);
    wr(1, 8'h01);
    wr(1, 8'h00);
    rd(1, r); chk("R2 mask after mode", r, 8'h00);

    // R3 R5 R6 R8 R12 per-input sweep, edge mode
    for (int n = 0; n < 8; n++) begin
      pulse(8'h01 << n);
      chk("R4 int", {7'd0, int_o}, 8'h01);
      rd(0, r); chk("R8 irr read", r, 8'h01 << n);
      ack(v); chk("R3 vector", v, 8'h30 + 8'(n));
      @(negedge clk);
      chk("R5 vld drop", {7'd0, vec_vld_o}, 8'h00);
      wr(0, 8'h0B);
      rd(0, r); chk("R5 isr set", r, 8'h01 << n);
      wr(0, 8'h0A);
      rd(0, r); chk("R12 edge cleared by ack", r, 8'h00);
      wr(0, 8'h60 + 8'(n));
      wr(0, 8'h0B);
      rd(0, r); chk("R6 isr cleared", r, 8'h00);
      wr(0, 8'h0A);
      chk("R4 int idle", {7'd0, int_o}, 8'h00);
    end

    // R3 exhaustive priority over all request patterns
    for (int p = 1; p < 256; p++) begin
      pulse(8'(p));
      pend = 8'(p);
      while (pend != 8'h00) begin
        chk("R4 int pend", {7'd0, int_o}, 8'h01);
        ack(v); chk("R3 priority", v, 8'h30 + 8'(lowest(pend)));
        chk("R13 blocked after ack", {7'd0, int_o}, 8'h00);
        wr(0, 8'h60 + 8'(lowest(pend)));
        pend = pend & ~(8'h01 << lowest(pend));
      end
      chk("R4 drained", {7'd0, int_o}, 8'h00);
    end

    // R13 nesting
    pulse(8'h08);
    ack(v); chk("R13 first", v, 8'h33);
    pulse(8'h20); chk("R13 lower blocked", {7'd0, int_o}, 8'h00);
    pulse(8'h08); chk("R13 equal blocked", {7'd0, int_o}, 8'h00);
    pulse(8'h02); chk("R13 higher nests", {7'd0, int_o}, 8'h01);
    ack(v); chk("R13 nested vec", v, 8'h31);
    wr(0, 8'h0B);
    rd(0, r); chk("R13 two in service", r, 8'h0A);
    wr(0, 8'h61);
    rd(0, r); chk("R6 only bit1 cleared", r, 8'h08);
    rd(0, r); chk("R8 select persists", r, 8'h08);
    wr(0, 8'h63);
    ack(v); chk("R13 pending 3", v, 8'h33);
    wr(0, 8'h63);
    ack(v); chk("R13 pending 5", v, 8'h35);
    wr(0, 8'h65);
    wr(0, 8'h0A);
    chk("R13 idle", {7'd0, int_o}, 8'h00);

    // R9 mask
    wr(1, 8'hFF);
    pulse(8'h04);
    chk("R9 masked", {7'd0, int_o}, 8'h00);
    rd(0, r); chk("R9 still latched", r, 8'h04);
    rd(1, r); chk("R8 mask read", r, 8'hFF);
    wr(1, 8'hFB);
    chk("R9 unmasked", {7'd0, int_o}, 8'h01);
    ack(v); chk("R9 vec", v, 8'h32);
    wr(0, 8'h62);
    wr(1, 8'h00);

    // R11 trigger register
    wr(2, 8'hFF);
    rd(2, r); chk("R11 reserved zero", r, 8'hF8);

    // R10 R12 level request gone before ack
    irq_i[5] = 1'b1; @(negedge clk);
    chk("R12 level int", {7'd0, int_o}, 8'h01);
    irq_i[5] = 1'b0; @(negedge clk);
    chk("R12 level drop", {7'd0, int_o}, 8'h00);
    ack(v); chk("R10 spurious vec", v, 8'h37);
    wr(0, 8'h0B);
    rd(0, r); chk("R10 isr untouched", r, 8'h00);
    wr(1, 8'hFF);
    ack(v); chk("R10 spurious masked 7", v, 8'h37);
    rd(0, r); chk("R10 isr untouched masked", r, 8'h00);
    wr(1, 8'h00);
    wr(0, 8'h0A);

    // R12 level follows input, not cleared by ack
    irq_i[4] = 1'b1; @(negedge clk);
    rd(0, r); chk("R12 level irr", r, 8'h10);
    ack(v); chk("R12 level vec", v, 8'h34);
    rd(0, r); chk("R12 level kept", r, 8'h10);
    irq_i[4] = 1'b0; @(negedge clk);
    rd(0, r); chk("R12 level follows", r, 8'h00);
    wr(0, 8'h64);

    // R11 reserved input 0 stays edge-sensed
    irq_i[0] = 1'b1; @(negedge clk);
    ack(v); chk("R11 vec", v, 8'h30);
    rd(0, r); chk("R11 edge on reserved", r, 8'h00);
    irq_i[0] = 1'b0;
    wr(0, 8'h60);
    wr(2, 8'h00);

    // R2 R7 reinit with auto end of service
    pulse(8'h02);
    ack(v); chk("R2 pre vec", v, 8'h31);
    pulse(8'h40);
    wr(0, 8'h11);
    chk("R2 int off in init", {7'd0, int_o}, 8'h00);
    wr(1, 8'h38);
    wr(1, 8'h04);
    chk("R2 int off before mode", {7'd0, int_o}, 8'h00);
    wr(1, 8'h03);
    chk("R2 int after init", {7'd0, int_o}, 8'h01);
    rd(1, r); chk("R2 mask kept", r, 8'h00);
    ack(v); chk("R7 new base vec", v, 8'h3E);
    wr(0, 8'h0B);
    rd(0, r); chk("R7 no isr", r, 8'h00);
    pulse(8'h44);
    ack(v); chk("R7 first", v, 8'h3A);
    chk("R7 not blocked", {7'd0, int_o}, 8'h01);
    ack(v); chk("R7 second", v, 8'h3E);
    rd(0, r); chk("R7 isr empty", r, 8'h00);

    summary();
  end

endmodule